// File: doc/BRIEF.md
# Per-Core Token-Bucket Bandwidth Regulator

This block sits in a memory controller in front of a non-volatile main memory and shares the device's service time among cores. The unit of service is a token, which stands for one device service cycle. Every core has two buckets, one for reads and one for writes. Each bucket gains tokens every clock at a rate that software writes. Reads and writes cost different numbers of tokens, and a write costs more than a read because the device takes longer to serve it.

Each core pushes requests into its own read queue or write queue, chosen by the request type. A queued request becomes eligible once its bucket holds at least its cost. The regulator issues one eligible request per cycle over a valid/ready port toward the device and takes the cost from the bucket on the handshake. The enqueue side uses the same back-pressure rules. A core may present a request at any time, and the request is taken only in a cycle where `req_valid` and `req_ready` are both high for that core. On the issue side, once `iss_valid` is raised the payload stays fixed until the device accepts it. A per-core stall flag tells the core when it must wait.

Rates are fixed point with `FRAC_W` fraction bits, so a core can get less than one token per cycle. Software is expected to keep the sum of all rates equal to the device's peak token rate, and to reprogram the rates once per epoch (about five million cycles).

Top module: `token_bucket_regulator`

## Requirements
- R1: For core c, `req_ready[c]` is high exactly when the queue selected by `req_write[c]` (0 = read queue, 1 = write queue) has a free slot. Each queue holds `QDEPTH` (default 4) requests, and a handshake stores the request in the selected queue.
- R2: A bucket gains `rate/2^FRAC_W` tokens every cycle, where `rate` is the 10-bit value last written for it (default `FRAC_W` = 8, so 256 means one token per cycle). A write with `cfg_we` high loads the read rate (`cfg_write` = 0) or the write rate (`cfg_write` = 1) of core `cfg_core`, and the new rate applies from the next cycle.
- R3: A request issues only if its bucket holds at least its cost in whole tokens (`cost_rd` for reads, `cost_wr` for writes), and that cost is deducted in the handshake cycle. With a steady backlog, a rate of 1.0 and a cost of 4, issues are spaced exactly 4 cycles apart.
- R4: A bucket whose rate is zero and which holds fewer tokens than its cost never issues a request.
- R5: `core_stall[c]` is high whenever core c has a read queued, and also whenever its write queue is full. Pending writes alone do not raise it while the write queue has a free slot.
- R6: Among eligible requests, the one accepted earliest issues first. Ties between requests accepted in the same cycle go to the lowest core index, and within one core the read goes before the write.
- R7: Once `iss_valid` is high with `iss_ready` low, `iss_valid`, `iss_core`, `iss_write` and `iss_addr` hold their values until the handshake.
- R8: A bucket never holds more than `bucket_cap` tokens. With a rate of 1.0, a cost of 4 and a cap of 8, a long wait followed by a backlog of four issues them with spacings of 1, 3 and 4 cycles.
- R9: After reset, all queues and buckets are empty, all rates are zero, `iss_valid` is low, all stall flags are low and every `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Per-core request valid |
| req_write | input | NCORE | Per-core request type, 1 = write |
| req_addr | input | NCORE*AW | Per-core request address, core c in bits [c*AW +: AW] |
| req_ready | output | NCORE | Per-core request accepted when high together with valid |
| iss_valid | output | 1 | A request is offered to the device |
| iss_ready | input | 1 | Device accepts the offered request |
| iss_core | output | log2(NCORE) | Core of the offered request |
| iss_write | output | 1 | Type of the offered request, 1 = write |
| iss_addr | output | AW | Address of the offered request |
| core_stall | output | NCORE | Per-core stall indication |
| cfg_we | input | 1 | Rate register write strobe |
| cfg_core | input | log2(NCORE) | Core whose rate is written |
| cfg_write | input | 1 | 0 selects read rate, 1 selects write rate |
| cfg_rate | input | RATE_W | Rate in tokens per cycle, FRAC_W fraction bits |
| cost_rd | input | TOK_W | Tokens taken by one read |
| cost_wr | input | TOK_W | Tokens taken by one write |
| bucket_cap | input | TOK_W | Maximum tokens a bucket may hold |

## Verification
The cap is the hardest behaviour to observe from the ports, because a bucket's fill level is never output and with a short queue a full bucket looks the same as a larger one. The stimulus holds `iss_ready` low while a core with a nonzero rate fills its queue and waits far longer than the cap allows. It then raises the cost so that the spacing of the released burst (1, 3, 4 cycles) shows the level it started from. First-come ordering is reached the same way: requests from several cores, some of them accepted in the same cycle, pile up behind a stalled device and are then released together.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  typedef enum logic { KIND_RD = 1'b0, KIND_WR = 1'b1 } req_kind_e;

  // Age of an entry relative to the free-running stamp; wrap-safe difference.
  function automatic logic [31:0] age_of(input logic [31:0] now, input logic [31:0] stamp);
    return now - stamp;
  endfunction
endpackage

// File: rtl/tbr_fifo.sv
module tbr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp_q, rp_q;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
  assign dout  = mem[rp_q[PW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push && !full) wp_q <= wp_q + 1'b1;
      if (pop && !empty) rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp_q[PW-1:0]] <= din;
  end
endmodule

// File: rtl/tbr_bucket.sv
module tbr_bucket #(
  parameter int TOK_W  = 8,
  parameter int FRAC_W = 8,
  parameter int RATE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic [TOK_W-1:0]  cap,
  input  logic [TOK_W-1:0]  cost,
  input  logic              consume,
  output logic              ok,
  output logic [TOK_W-1:0]  tokens
);
  localparam int LW = TOK_W + FRAC_W;
  localparam int XW = LW + 2;

  logic [LW-1:0] lvl_q, lvl_d;
  logic [XW-1:0] lvl_x, cost_x, cap_x, base_x, sum_x;

  always_comb begin
    lvl_x  = XW'(lvl_q);
    cost_x = XW'({cost, {FRAC_W{1'b0}}});
    cap_x  = XW'({cap, {FRAC_W{1'b0}}});
    if (consume) base_x = (lvl_x >= cost_x) ? (lvl_x - cost_x) : '0;
    else         base_x = lvl_x;
    sum_x = base_x + XW'(rate);
    lvl_d = (sum_x > cap_x) ? cap_x[LW-1:0] : sum_x[LW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign tokens = lvl_q[LW-1:FRAC_W];
  assign ok     = (tokens >= cost);
endmodule

// File: rtl/tbr_pick.sv
module tbr_pick #(
  parameter int N    = 8,
  parameter int TS_W = 32
) (
  input  logic [N-1:0]      cand,
  input  logic [N*TS_W-1:0] age,
  output logic              any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  logic [TS_W-1:0] best;

  // Oldest candidate wins; strict compare keeps the lowest slot on a tie.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || (age[i*TS_W +: TS_W] > best))) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = age[i*TS_W +: TS_W];
      end
    end
  end
endmodule

// File: rtl/token_bucket_regulator.sv
module token_bucket_regulator #(
  parameter int NCORE    = 4,
  parameter int AW       = 32,
  parameter int QDEPTH   = 4,
  parameter int TOK_W    = 8,
  parameter int FRAC_W   = 8,
  parameter int RATE_INT = 2,
  parameter int TS_W     = 32,
  localparam int CW      = $clog2(NCORE),
  localparam int RATE_W  = RATE_INT + FRAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    req_valid,
  input  logic [NCORE-1:0]    req_write,
  input  logic [NCORE*AW-1:0] req_addr,
  output logic [NCORE-1:0]    req_ready,
  output logic                iss_valid,
  input  logic                iss_ready,
  output logic [CW-1:0]       iss_core,
  output logic                iss_write,
  output logic [AW-1:0]       iss_addr,
  output logic [NCORE-1:0]    core_stall,
  input  logic                cfg_we,
  input  logic [CW-1:0]       cfg_core,
  input  logic                cfg_write,
  input  logic [RATE_W-1:0]   cfg_rate,
  input  logic [TOK_W-1:0]    cost_rd,
  input  logic [TOK_W-1:0]    cost_wr,
  input  logic [TOK_W-1:0]    bucket_cap
);
  import tbr_pkg::*;

  localparam int NS = 2 * NCORE;        // slot = 2*core + kind
  localparam int SI = $clog2(NS);
  localparam int EW = AW + TS_W;

  logic [TS_W-1:0]    now_q;
  logic [RATE_W-1:0]  rate_q [NS];
  logic [NS-1:0]      s_empty, s_full, s_ok, s_pop;
  logic [AW-1:0]      s_addr [NS];
  logic [TS_W-1:0]    s_ts   [NS];
  logic [NS*TS_W-1:0] s_age;
  logic [NS*TOK_W-1:0] s_tok;

  logic          pick_any;
  logic [SI-1:0] pick_idx, sel_idx, hold_idx_q;
  logic          hold_q, fire;

  // Arrival stamp shared by all queues.
  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  // Rate registers, effective the cycle after the write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) rate_q[i] <= '0;
    end else if (cfg_we) begin
      rate_q[{cfg_core, cfg_write}] <= cfg_rate;
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_slot
    localparam int CORE = s / 2;
    localparam req_kind_e KIND = (s % 2 == 1) ? KIND_WR : KIND_RD;

    logic          push;
    logic [EW-1:0] q_dout;
    logic [TOK_W-1:0] cost;

    assign push = req_valid[CORE] && (req_write[CORE] == (KIND == KIND_WR)) && !s_full[s];
    assign cost = (KIND == KIND_WR) ? cost_wr : cost_rd;

    tbr_fifo #(.W(EW), .DEPTH(QDEPTH)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push),
      .din  ({req_addr[CORE*AW +: AW], now_q}),
      .pop  (s_pop[s]),
      .dout (q_dout),
      .empty(s_empty[s]),
      .full (s_full[s])
    );

    tbr_bucket #(.TOK_W(TOK_W), .FRAC_W(FRAC_W), .RATE_W(RATE_W)) u_bkt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rate   (rate_q[s]),
      .cap    (bucket_cap),
      .cost   (cost),
      .consume(s_pop[s]),
      .ok     (s_ok[s]),
      .tokens (s_tok[s*TOK_W +: TOK_W])
    );

    assign s_addr[s] = q_dout[EW-1:TS_W];
    assign s_ts[s]   = q_dout[TS_W-1:0];
    assign s_age[s*TS_W +: TS_W] = TS_W'(age_of(32'(now_q), 32'(s_ts[s])));
    assign s_pop[s]  = fire && (sel_idx == SI'(s));
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign req_ready[c]  = req_write[c] ? !s_full[2*c+1] : !s_full[2*c];
    assign core_stall[c] = !s_empty[2*c] || s_full[2*c+1];
  end

  tbr_pick #(.N(NS), .TS_W(TS_W)) u_pick (
    .cand(~s_empty & s_ok),
    .age (s_age),
    .any (pick_any),
    .idx (pick_idx)
  );

  // A refused offer is pinned so the payload stays stable until taken.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= iss_valid && !iss_ready;
      hold_idx_q <= sel_idx;
    end
  end

  assign sel_idx   = hold_q ? hold_idx_q : pick_idx;
  assign iss_valid = hold_q || pick_any;
  assign fire      = iss_valid && iss_ready;
  assign iss_core  = CW'(sel_idx >> 1);
  assign iss_write = sel_idx[0];
  assign iss_addr  = s_addr[sel_idx];
endmodule

// File: rtl/tbr_checker.sv
module tbr_checker #(
  parameter int NCORE = 4,
  parameter int AW    = 32,
  parameter int TOK_W = 8,
  localparam int CW   = $clog2(NCORE),
  localparam int NS   = 2 * NCORE,
  localparam int SI   = $clog2(NS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCORE-1:0]    req_valid,
  input logic [NCORE-1:0]    req_write,
  input logic [NCORE-1:0]    req_ready,
  input logic                iss_valid,
  input logic                iss_ready,
  input logic [CW-1:0]       iss_core,
  input logic                iss_write,
  input logic [AW-1:0]       iss_addr,
  input logic [NCORE-1:0]    core_stall,
  input logic [TOK_W-1:0]    cost_rd,
  input logic [TOK_W-1:0]    cost_wr,
  input logic [TOK_W-1:0]    bucket_cap,
  input logic [NS*TOK_W-1:0] tok_flat
);
  logic [SI-1:0]    slot;
  logic [TOK_W-1:0] need;
  assign slot = {iss_core, iss_write};
  assign need = iss_write ? cost_wr : cost_rd;

  // R3: a handshake only happens when the issuing bucket covers the cost
  a_r3_fire_covered: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> (tok_flat[slot*TOK_W +: TOK_W] >= need));

  // R7: a refused offer is held unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_core) && $stable(iss_write) && $stable(iss_addr)));

  for (genvar s = 0; s < NS; s++) begin : g_s
    // R8: the fill never passes the cap in force one cycle earlier
    a_r8_cap: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (tok_flat[s*TOK_W +: TOK_W] <= $past(bucket_cap)));
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_c
    // R5: an accepted read leaves the core stalled in the next cycle
    a_r5_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[c] && !req_write[c] && req_ready[c]) |=> core_stall[c]);
  end
endmodule

bind token_bucket_regulator tbr_checker #(.NCORE(NCORE), .AW(AW), .TOK_W(TOK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_ready (req_ready),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_core  (iss_core),
  .iss_write (iss_write),
  .iss_addr  (iss_addr),
  .core_stall(core_stall),
  .cost_rd   (cost_rd),
  .cost_wr   (cost_wr),
  .bucket_cap(bucket_cap),
  .tok_flat  (s_tok)
);

// File: tb/token_bucket_regulator_tb.sv
module token_bucket_regulator_tb;
  localparam int NC = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]    req_valid, req_write, req_ready, core_stall;
  logic [NC*AW-1:0] req_addr;
  logic             iss_valid, iss_ready, iss_write;
  logic [1:0]       iss_core;
  logic [AW-1:0]    iss_addr;
  logic             cfg_we, cfg_write;
  logic [1:0]       cfg_core;
  logic [9:0]       cfg_rate;
  logic [7:0]       cost_rd, cost_wr, bucket_cap;

  always #2 clk = ~clk;

  token_bucket_regulator u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_ready(req_ready),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_core(iss_core), .iss_write(iss_write),
    .iss_addr(iss_addr), .core_stall(core_stall),
    .cfg_we(cfg_we), .cfg_core(cfg_core), .cfg_write(cfg_write), .cfg_rate(cfg_rate),
    .cost_rd(cost_rd), .cost_wr(cost_wr), .bucket_cap(bucket_cap)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n_iss = 0;
  int issue_cyc [64];
  int exp_q [$];
  string cur_req = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pack_item(input int core, input int wr, input int addr);
    return (core << 17) | (wr << 16) | (addr & 16'hffff);
  endfunction

  task automatic exp_push(input int core, input int wr, input int addr);
    exp_q.push_back(pack_item(core, wr, addr));
  endtask

  // Monitor: compare each handshake with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && iss_valid && iss_ready) begin
      int act;
      int exp;
      act = pack_item(int'(iss_core), int'(iss_write), int'(iss_addr[15:0]));
      if (exp_q.size() == 0) exp = -1;
      else exp = exp_q.pop_front();
      chk(cur_req, act == exp, act, exp);
      if (n_iss < 64) issue_cyc[n_iss] = cyc;
      n_iss++;
    end
  end

  task automatic enq(input int core, input logic wr, input int addr);
    @(posedge clk); #1;
    req_valid[core] = 1'b1;
    req_write[core] = wr;
    req_addr[core*AW +: AW] = AW'(addr);
    @(posedge clk); #1;
    req_valid = '0;
  endtask

  task automatic set_req(input int core, input logic wr, input int addr);
    req_valid[core] = 1'b1;
    req_write[core] = wr;
    req_addr[core*AW +: AW] = AW'(addr);
  endtask

  task automatic cfg(input int core, input logic wr, input int rate);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_core = 2'(core); cfg_write = wr; cfg_rate = 10'(rate);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_iss(input int n, input string req);
    int guard = 0;
    while (n_iss < n && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(req, n_iss >= n, n_iss, n);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [1:0]  h_core;
    logic [AW-1:0] h_addr;
    rst_n = 1'b0; req_valid = '0; req_write = '0; req_addr = '0; iss_ready = 1'b1;
    cfg_we = 1'b0; cfg_write = 1'b0; cfg_core = '0; cfg_rate = '0;
    cost_rd = 8'd2; cost_wr = 8'd4; bucket_cap = 8'd8;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9", iss_valid == 1'b0, iss_valid, 0);
    chk("R9", core_stall == '0, core_stall, 0);
    chk("R9", req_ready == '1, req_ready, 4'hf);

    // Zero-rate read on core 1 stays put and stalls the core.
    enq(1, 1'b0, 'h100);
    repeat (30) @(negedge clk);
    chk("R4", iss_valid == 1'b0, iss_valid, 0);
    chk("R5", core_stall[1] == 1'b1, core_stall[1], 1);

    // Writes on core 2 with zero rate: stall only once the write queue fills.
    for (int i = 0; i < 3; i++) enq(2, 1'b1, 'h200 + i);
    chk("R5", core_stall[2] == 1'b0, core_stall[2], 0);
    enq(2, 1'b1, 'h203);
    chk("R5", core_stall[2] == 1'b1, core_stall[2], 1);
    req_write[2] = 1'b1; #1;
    chk("R1", req_ready[2] == 1'b0, req_ready[2], 0);
    req_write[2] = 1'b0; #1;
    chk("R1", req_ready[2] == 1'b1, req_ready[2], 1);

    // R2/R3: rate 1.0, write cost 4 -> one write every 4 cycles.
    cur_req = "R3";
    for (int i = 0; i < 4; i++) exp_push(2, 1, 'h200 + i);
    cfg(2, 1'b1, 256);
    wait_iss(4, "R3");
    for (int i = 1; i < 4; i++)
      chk("R3", issue_cyc[i] - issue_cyc[i-1] == 4, issue_cyc[i] - issue_cyc[i-1], 4);

    // R2: fractional rate 0.5 with read cost 2 -> spacing 4.
    cur_req = "R2";
    exp_push(1, 0, 'h100);
    cfg(1, 1'b0, 128);
    wait_iss(5, "R2");
    for (int i = 0; i < 4; i++) begin
      exp_push(1, 0, 'h110 + i);
      enq(1, 1'b0, 'h110 + i);
    end
    wait_iss(9, "R2");
    for (int i = 7; i < 9; i++)
      chk("R2", issue_cyc[i] - issue_cyc[i-1] == 4, issue_cyc[i] - issue_cyc[i-1], 4);

    // R8/R7: capped bucket, stalled device, then release.
    cur_req = "R8";
    @(posedge clk); #1;
    cost_wr = 8'd5; cost_rd = 8'd4; iss_ready = 1'b0;
    cfg(3, 1'b0, 256);
    for (int i = 0; i < 4; i++) begin
      exp_push(3, 0, 'h300 + i);
      enq(3, 1'b0, 'h300 + i);
    end
    repeat (40) @(negedge clk);
    chk("R7", iss_valid == 1'b1, iss_valid, 1);
    h_core = iss_core; h_addr = iss_addr;
    repeat (3) @(negedge clk);
    chk("R7", iss_valid == 1'b1 && iss_core == h_core && iss_addr == h_addr, int'(iss_addr), int'(h_addr));
    chk("R5", core_stall[3] == 1'b1, core_stall[3], 1);
    chk("R1", req_ready[3] == 1'b0, req_ready[3], 0);
    @(posedge clk); #1 iss_ready = 1'b1;
    wait_iss(13, "R8");
    chk("R8", issue_cyc[10] - issue_cyc[9] == 1, issue_cyc[10] - issue_cyc[9], 1);
    chk("R8", issue_cyc[11] - issue_cyc[10] == 3, issue_cyc[11] - issue_cyc[10], 3);
    chk("R8", issue_cyc[12] - issue_cyc[11] == 4, issue_cyc[12] - issue_cyc[11], 4);

    // R6: arrival order, same-cycle ties by core index.
    cur_req = "R6";
    @(posedge clk); #1;
    cost_rd = 8'd1; cost_wr = 8'd2; iss_ready = 1'b0;
    for (int c = 0; c < NC; c++) cfg(c, 1'b0, 256);
    cfg(1, 1'b1, 256);
    enq(3, 1'b0, 'h400);
    enq(1, 1'b0, 'h401);
    @(posedge clk); #1;
    set_req(2, 1'b0, 'h403);
    set_req(1, 1'b1, 'h404);
    set_req(0, 1'b0, 'h402);
    @(posedge clk); #1;
    req_valid = '0;
    exp_push(3, 0, 'h400);
    exp_push(1, 0, 'h401);
    exp_push(0, 0, 'h402);
    exp_push(1, 1, 'h404);
    exp_push(2, 0, 'h403);
    repeat (12) @(negedge clk);
    @(posedge clk); #1 iss_ready = 1'b1;
    wait_iss(18, "R6");
    repeat (4) @(negedge clk);
    chk("R6", exp_q.size() == 0, exp_q.size(), 0);
    chk("R5", core_stall == '0, core_stall, 0);
    finish_run();
  end
endmodule